// File: doc/BRIEF.md
# DMA Transfer Count Bank

This block holds one transfer count register for each channel of a DMA controller. Software programs a channel's count over a small 32-bit register bus. The controller then starts the channel and pulses a decrement strobe once for each finished transfer unit. The register counts down from the programmed value, and the bus reads back how many transfers are still left. The block raises a one-cycle terminal pulse when the last transfer of a run completes.

Only the lower 24 bits of each register are stored. A programmed zero does not mean an empty run: it means the largest possible run of 2^24 transfers. Channel 0 has a second load path. A 64-bit request word can replace the low byte of its count while the upper stored bits keep their values.

Each channel runs a two-state machine. IDLE is the state after reset. The START transition (IDLE to RUN) happens on that channel's start strobe. RUN is where decrement strobes take effect. The FINISH transition (RUN to IDLE) happens on the decrement that takes the count from 1 to 0, and it produces the terminal pulse.

Top module: `dma_xfer_count_bank`

## Requirements
- R1: A read of channel `reg_sel` returns the stored 24-bit count in bits 23:0 and zero in bits 31:24. Write data in bits 31:24 is discarded.
- R2: A bus write to one channel leaves the counts of the other channels unchanged.
- R3: In RUN, each decrement strobe lowers that channel's count by one. A read returns the new remaining count in the cycle after the strobe.
- R4: A decrement in RUN that takes the count from 1 to 0 holds `tc_pulse[ch]` high for exactly the following cycle. The channel then returns to IDLE.
- R5: A channel started with a stored count of 0 runs 2^24 transfers. Its first decrement gives 0xFFFFFF and produces no terminal pulse.
- R6: A decrement strobe on a channel in IDLE changes nothing: the count keeps its value and no terminal pulse occurs.
- R7: When a bus write and a decrement reach the same channel in the same cycle, the written value is stored, the decrement is lost and no terminal pulse occurs.
- R8: When `side_we` is high, channel 0 bits 7:0 take `side_word[55:48]`. Channel 0 bits 23:8 keep their values.
- R9: When a side load and a bus write to channel 0 occur in the same cycle, only the bus write takes effect. A side load in the same cycle as a bus write to another channel still updates channel 0.
- R10: A start strobe on a channel that is already in RUN has no effect on its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; puts every channel in IDLE |
| reg_sel | input | 2 | Channel selected for read and write |
| reg_we | input | 1 | Write strobe for the selected channel |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected channel |
| ch_start | input | 4 | Per-channel start strobe |
| ch_dec | input | 4 | Per-channel decrement strobe, one per finished transfer unit |
| side_we | input | 1 | Side load strobe for channel 0's low byte |
| side_word | input | 64 | Request word; bits 55:48 feed the side load |
| tc_pulse | output | 4 | Per-channel terminal-count pulse |

## Verification
A wrong count shows up on the read bus in the cycle right after the decrement that caused it, because the read path has no register in it. A wrong state shows up in other ways:
- A channel stuck in IDLE ignores its decrements, and this is visible on the next read.
- A channel stuck in RUN keeps counting after its terminal pulse.
- A missing or extra terminal pulse shows up on `tc_pulse` one cycle after the last decrement.

The sweeps count every channel down from several lengths and read the count after every strobe, so a fault appears within one cycle of its cause.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/dxc_channel.sv
module dxc_channel
    import dxc_pkg::*;
#(
    parameter int CW = 24,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_val,
    input  logic          ld_en,
    input  logic [LW-1:0] ld_val,
    input  logic          start,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          tc
);
    ch_state_e state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic          tc_q, tc_d;
    logic          take_dec, last_unit;

    assign take_dec  = (state_q == CH_RUN) && dec && !wr_en && !ld_en;
    assign last_unit = take_dec && (count_q == CW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (start)     state_d = CH_RUN;
            CH_RUN:  if (last_unit) state_d = CH_IDLE;
            default:                state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        count_d = count_q;
        tc_d    = 1'b0;
        if (wr_en) begin
            count_d = wr_val;
        end else if (ld_en) begin
            count_d = {count_q[CW-1:LW], ld_val};
        end else if (take_dec) begin
            count_d = count_q - CW'(1);
            tc_d    = last_unit;
        end
    end

    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= tc_d;
    end

    assign count = count_q;
    assign tc    = tc_q;
endmodule

// File: rtl/dxc_readmux.sv
module dxc_readmux #(
    parameter int NCH = 4,
    parameter int CW  = 24,
    parameter int DW  = 32,
    localparam int SW = $clog2(NCH)
) (
    input  logic [NCH-1:0][CW-1:0] counts,
    input  logic [SW-1:0]          sel,
    output logic [DW-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        rdata[CW-1:0] = counts[sel];
    end
endmodule

// File: rtl/dma_xfer_count_bank.sv
module dma_xfer_count_bank #(
    parameter int NCH    = 4,
    parameter int CW     = 24,
    parameter int DW     = 32,
    parameter int RW     = 64,
    parameter int LD_LSB = 48,
    parameter int LW     = 8,
    localparam int SW    = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] reg_sel,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NCH-1:0] ch_start,
    input  logic [NCH-1:0] ch_dec,
    input  logic          side_we,
    input  logic [RW-1:0] side_word,
    output logic [NCH-1:0] tc_pulse
);
    logic [NCH-1:0][CW-1:0] counts;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ld_here;
        if (g == 0) begin : g_side
            assign ld_here = side_we;
        end else begin : g_noside
            assign ld_here = 1'b0;
        end

        dxc_channel #(.CW(CW), .LW(LW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (reg_we && (reg_sel == SW'(g))),
            .wr_val (reg_wdata[CW-1:0]),
            .ld_en  (ld_here),
            .ld_val (side_word[LD_LSB +: LW]),
            .start  (ch_start[g]),
            .dec    (ch_dec[g]),
            .count  (counts[g]),
            .tc     (tc_pulse[g])
        );
    end

    dxc_readmux #(.NCH(NCH), .CW(CW), .DW(DW)) u_rd (
        .counts (counts),
        .sel    (reg_sel),
        .rdata  (reg_rdata)
    );
endmodule

// File: rtl/dxc_checker.sv
module dxc_checker #(
    parameter int NCH    = 4,
    parameter int CW     = 24,
    parameter int DW     = 32,
    parameter int RW     = 64,
    parameter int LD_LSB = 48,
    parameter int LW     = 8,
    localparam int SW    = $clog2(NCH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] reg_sel,
    input logic          reg_we,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [NCH-1:0] ch_start,
    input logic [NCH-1:0] ch_dec,
    input logic          side_we,
    input logic [RW-1:0] side_word,
    input logic [NCH-1:0] tc_pulse
);
    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:CW] == '0);

    // R7
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_sel != $past(reg_sel)) ||
                   (reg_rdata[CW-1:0] == $past(reg_wdata[CW-1:0])));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R4
        tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[g] |=> !tc_pulse[g]);

        // R4
        tc_after_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tc_pulse[g]) |-> $past(ch_dec[g]));

        // R7
        tc_not_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tc_pulse[g]) |-> !$past(reg_we && (reg_sel == SW'(g))));
    end
endmodule

bind dma_xfer_count_bank dxc_checker #(
    .NCH(NCH), .CW(CW), .DW(DW), .RW(RW), .LD_LSB(LD_LSB), .LW(LW)
) u_chk (.*);

// File: tb/tb_dma_xfer_count_bank.sv
`timescale 1ns/1ps
module tb_dma_xfer_count_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  ch_start = '0;
    logic [3:0]  ch_dec = '0;
    logic        side_we = 1'b0;
    logic [63:0] side_word = '0;
    logic [3:0]  tc_pulse;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_xfer_count_bank dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input logic [31:0] v);
        @(negedge clk);
        reg_sel = 2'(ch); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [31:0] rd(input int ch);
        return 32'(0);
    endfunction

    task automatic rdchk(input string req, input int ch, input logic [31:0] exp);
        reg_sel = 2'(ch);
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic start(input int ch);
        @(negedge clk);
        ch_start[ch] = 1'b1;
        @(negedge clk);
        ch_start[ch] = 1'b0;
    endtask

    task automatic dec(input int ch);
        @(negedge clk);
        ch_dec[ch] = 1'b1;
        @(negedge clk);
        ch_dec[ch] = 1'b0;
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: reserved bits zero, no terminal pulse
        chk("R1 reset rsv", {24'd0, reg_rdata[31:24]}, 32'd0);
        chk("R4 reset tc", {28'd0, tc_pulse}, 32'd0);
        rst_n = 1'b1;

        // R1 R2: write all channels, upper byte discarded, no cross effects
        for (int c = 0; c < 4; c++) wr(c, {8'hFF, 24'(32'h00A5_0000 + c * 32'h1111)});
        for (int c = 0; c < 4; c++) rdchk("R1 R2 readback", c, 32'(32'h00A5_0000 + c * 32'h1111));

        // R3 R4: sweep every channel over lengths 1..6
        for (int c = 0; c < 4; c++) begin
            for (int n = 1; n <= 6; n++) begin
                wr(c, 32'(n));
                start(c);
                for (int k = 1; k <= n; k++) begin
                    dec(c);
                    rdchk("R3 remaining", c, 32'(n - k));
                    chk("R4 tc level", {31'd0, tc_pulse[c]}, {31'd0, k == n});
                    chk("R4 other tc", {28'd0, tc_pulse & ~(4'b1 << c)}, 32'd0);
                end
                @(negedge clk);
                chk("R4 tc single", {31'd0, tc_pulse[c]}, 32'd0);
                // R4 R6: channel now idle, further decrement ignored
                wr(c, 32'd9);
                dec(c);
                rdchk("R6 idle dec", c, 32'd9);
                chk("R6 no tc", {31'd0, tc_pulse[c]}, 32'd0);
            end
        end

        // R5: zero means 2^24 transfers, wraps to 0xFFFFFF without tc
        wr(2, 32'd0);
        start(2);
        dec(2);
        rdchk("R5 wrap", 2, 32'h00FF_FFFF);
        chk("R5 no tc", {31'd0, tc_pulse[2]}, 32'd0);
        dec(2);
        rdchk("R5 next", 2, 32'h00FF_FFFE);

        // R10: start while running does not touch count
        start(2);
        rdchk("R10 restart", 2, 32'h00FF_FFFE);

        // R7: write and decrement in same cycle, write wins
        wr(2, 32'd1);
        @(negedge clk);
        reg_sel = 2'd2; reg_we = 1'b1; reg_wdata = 32'd1; ch_dec[2] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; ch_dec[2] = 1'b0;
        rdchk("R7 write wins", 2, 32'd1);
        chk("R7 no tc", {31'd0, tc_pulse[2]}, 32'd0);
        dec(2);
        chk("R7 later tc", {31'd0, tc_pulse[2]}, 32'd1);

        // R8: side load replaces low byte only
        wr(0, 32'h0012_3456);
        @(negedge clk);
        side_we = 1'b1; side_word = 64'h0000_0000_0000_0000 | (64'hC3 << 48) | 64'hFFFF;
        @(negedge clk);
        side_we = 1'b0;
        rdchk("R8 side load", 0, 32'h0012_34C3);

        // R9: side load with write to channel 0, write wins
        @(negedge clk);
        side_we = 1'b1; side_word = 64'h7E << 48;
        reg_sel = 2'd0; reg_we = 1'b1; reg_wdata = 32'h0000_0777;
        @(negedge clk);
        side_we = 1'b0; reg_we = 1'b0;
        rdchk("R9 write wins", 0, 32'h0000_0777);

        // R9: side load alongside write to another channel, both land
        @(negedge clk);
        side_we = 1'b1; side_word = 64'h5A << 48;
        reg_sel = 2'd3; reg_we = 1'b1; reg_wdata = 32'h0000_4242;
        @(negedge clk);
        side_we = 1'b0; reg_we = 1'b0;
        rdchk("R9 side ch0", 0, 32'h0000_075A);
        rdchk("R9 write ch3", 3, 32'h0000_4242);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule